// File: doc/BRIEF.md
# MDIO Management Master

This block runs one Clause-22 management frame toward an Ethernet PHY for each command that software places into a single 32-bit command/status word. The word packs a request flag, a direction flag, a 5-bit PHY address, a 5-bit register address and 16 data bits. When the request flag is written as 1 while the block is idle, the block builds the whole frame. It shifts the frame out on MDIO against a divided management clock (MDC), and it clears the request flag when the last bit has gone by.

For a read, the block releases MDIO from the turnaround onward. It samples the PHY's 16 answer bits and leaves them in the low half of the same word. Software therefore polls one location: it waits for bit 31 to drop, then takes the result from bits 15:0. The MDIO pad is split into output, output-enable and input so that the tristate buffer sits outside the block.

Top module: `mdio_mgmt_master`

## Requirements
- R1: Writing a word with bit 31 = 1 while bit 31 reads 0 starts one frame. Bit 31 reads 1 from the next cycle until the frame ends, then reads 0. A word written with bit 31 = 0 is stored as written and starts no frame.
- R2: Bit 30 = 1 requests a read, sent as opcode bits 1,0. Bit 30 = 0 requests a write, sent as opcode bits 0,1.
- R3: The PHY address (bits 25:21) follows the opcode MSB first. The register address (bits 20:16) comes after it, also MSB first.
- R4: On a write, the turnaround is driven as 1 then 0, followed by bits 15:0 MSB first. MDIO is driven for every bit of the frame.
- R5: On a read, MDIO is released for both turnaround bits and all 16 data bits. The 16 bits sampled on MDC rising edges (MSB first) appear in bits 15:0 when bit 31 clears, and bits 30:16 keep the values written.
- R6: Every frame lasts 64 MDC periods. It opens with 32 driven ones and then the start pair 0,1.
- R7: Any write to the word while bit 31 reads 1 is ignored: it changes no stored bit and starts no extra frame.
- R8: During a frame, MDC has a period of 2 × MDC_HALF_DIV system clocks. MDIO output changes only in the cycle where MDC falls, apart from the first bit, which is driven in the cycle the command is accepted.
- R9: After reset the word reads 0, MDC is low and MDIO is released.
- R10: Once bit 31 has cleared, MDC is low and MDIO is released until the next command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_wr_en | input | 1 | Write strobe for the command/status word |
| csr_wr_data | input | 32 | Word to write |
| csr_rd_data | output | 32 | Current command/status word |
| mdc | output | 1 | Management clock to the PHY |
| mdio_out | output | 1 | Value driven on MDIO |
| mdio_oe | output | 1 | MDIO output enable (1 = block drives the line) |
| mdio_in | input | 1 | Value sensed on the MDIO line |

## Verification
The hardest case to reach is a second command word that arrives while a frame is mid-flight. The block must then keep the stored fields untouched and raise no second frame, and the captured read value must still land intact. The stimulus issues a read, waits a few cycles, and writes a fresh command with the request flag set. It then checks the register after completion and waits a further stretch to confirm that MDC stays still. The read path also depends on a PHY model that follows MDC edges. The model counts rising edges to decide when to answer, and drives a value derived from the address fields so that each bit position is distinguishable.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

    localparam int FRAME_BITS    = 64;
    localparam int PREAMBLE_BITS = 32;
    localparam int DATA_BITS     = 16;
    localparam int ADDR_BITS     = 5;
    localparam int IDX_W         = $clog2(FRAME_BITS);

    typedef logic [IDX_W-1:0] bit_idx_t;

    // bit position where a read stops driving (first turnaround bit)
    localparam bit_idx_t RD_RELEASE_IDX = bit_idx_t'(FRAME_BITS - DATA_BITS - 2);
    // first bit position carrying PHY data
    localparam bit_idx_t RD_DATA_IDX    = bit_idx_t'(FRAME_BITS - DATA_BITS);
    localparam bit_idx_t LAST_IDX       = bit_idx_t'(FRAME_BITS - 1);

    localparam logic [1:0] START_PAIR = 2'b01;
    localparam logic [1:0] OP_WRITE   = 2'b01;
    localparam logic [1:0] OP_READ    = 2'b10;
    localparam logic [1:0] TA_WRITE   = 2'b10;

    typedef struct packed {
        logic                 go;
        logic                 is_read;
        logic [3:0]           spare;
        logic [ADDR_BITS-1:0] phy_addr;
        logic [ADDR_BITS-1:0] reg_addr;
        logic [DATA_BITS-1:0] data;
    } cmd_word_t;

    typedef logic [FRAME_BITS-1:0] frame_vec_t;

    // Assemble the full frame, first bit on the wire in the MSB.
    function automatic frame_vec_t build_frame(cmd_word_t c);
        logic [1:0]           op;
        logic [1:0]           ta;
        logic [DATA_BITS-1:0] payload;
        op      = c.is_read ? OP_READ : OP_WRITE;
        ta      = c.is_read ? 2'b11 : TA_WRITE;
        payload = c.is_read ? {DATA_BITS{1'b1}} : c.data;
        return {{PREAMBLE_BITS{1'b1}}, START_PAIR, op,
                c.phy_addr, c.reg_addr, ta, payload};
    endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic mdc,
    output logic rise_tick,
    output logic fall_tick
);
    logic tick;

    generate
        if (HALF_DIV <= 1) begin : g_direct
            // MDC toggles on every system clock while running
            assign tick = run;
        end else begin : g_count
            localparam int CNT_W = $clog2(HALF_DIV);
            localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(HALF_DIV - 1);
            logic [CNT_W-1:0] cnt_q;

            always_ff @(posedge clk) begin
                if (rst || !run) begin
                    cnt_q <= '0;
                end else if (cnt_q == CNT_TOP) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end

            assign tick = run && (cnt_q == CNT_TOP);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            mdc <= 1'b0;
        end else if (tick) begin
            mdc <= ~mdc;
        end
    end

    assign rise_tick = tick && !mdc;
    assign fall_tick = tick && mdc;

endmodule

// File: rtl/mdio_frame_shifter.sv
module mdio_frame_shifter
    import mdio_mgmt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  cmd_word_t            cmd,
    input  logic                 rise_tick,
    input  logic                 fall_tick,
    input  logic                 mdio_in,
    output logic                 active,
    output logic                 mdio_out,
    output logic                 mdio_oe,
    output logic                 done,
    output logic [DATA_BITS-1:0] rd_val
);
    frame_vec_t           frame_q;
    bit_idx_t             idx_q;
    bit_idx_t             idx_nxt;
    logic                 is_rd_q;
    logic [DATA_BITS-1:0] cap_q;
    logic                 last_bit;

    assign idx_nxt  = idx_q + 1'b1;
    assign last_bit = (idx_q == LAST_IDX);
    assign done     = active && fall_tick && last_bit;
    assign rd_val   = cap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active   <= 1'b0;
            frame_q  <= '0;
            idx_q    <= '0;
            is_rd_q  <= 1'b0;
            cap_q    <= '0;
            mdio_out <= 1'b1;
            mdio_oe  <= 1'b0;
        end else if (start) begin
            active   <= 1'b1;
            frame_q  <= build_frame(cmd);
            idx_q    <= '0;
            is_rd_q  <= cmd.is_read;
            mdio_out <= 1'b1;
            mdio_oe  <= 1'b1;
        end else if (active) begin
            if (rise_tick && is_rd_q && (idx_q >= RD_DATA_IDX)) begin
                cap_q <= {cap_q[DATA_BITS-2:0], mdio_in};
            end
            if (fall_tick) begin
                if (last_bit) begin
                    active  <= 1'b0;
                    mdio_oe <= 1'b0;
                end else begin
                    idx_q    <= idx_nxt;
                    frame_q  <= frame_q << 1;
                    mdio_out <= frame_q[FRAME_BITS-2];
                    mdio_oe  <= !(is_rd_q && (idx_nxt >= RD_RELEASE_IDX));
                end
            end
        end
    end

endmodule

// File: rtl/mdio_cmd_reg.sv
module mdio_cmd_reg
    import mdio_mgmt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [31:0]          wr_data,
    input  logic                 done,
    input  logic [DATA_BITS-1:0] rd_val,
    output cmd_word_t            cmd_q,
    output logic                 start
);
    cmd_word_t wr_word;

    assign wr_word = cmd_word_t'(wr_data);
    assign start   = wr_en && !cmd_q.go && wr_word.go;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
        end else if (done) begin
            cmd_q.go <= 1'b0;
            if (cmd_q.is_read) begin
                cmd_q.data <= rd_val;
            end
        end else if (wr_en && !cmd_q.go) begin
            cmd_q <= wr_word;
        end
    end

endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
    import mdio_mgmt_pkg::*;
#(
    parameter int MDC_HALF_DIV = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        csr_wr_en,
    input  logic [31:0] csr_wr_data,
    output logic [31:0] csr_rd_data,
    output logic        mdc,
    output logic        mdio_out,
    output logic        mdio_oe,
    input  logic        mdio_in
);
    cmd_word_t            cmd;
    logic                 start;
    logic                 done;
    logic                 active;
    logic                 rise_tick;
    logic                 fall_tick;
    logic [DATA_BITS-1:0] rd_val;

    mdio_cmd_reg u_cmd (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (csr_wr_en),
        .wr_data (csr_wr_data),
        .done    (done),
        .rd_val  (rd_val),
        .cmd_q   (cmd),
        .start   (start)
    );

    mdio_mdc_gen #(
        .HALF_DIV (MDC_HALF_DIV)
    ) u_clk (
        .clk       (clk),
        .rst       (rst),
        .run       (active),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_frame_shifter u_shift (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .cmd       (cmd_word_t'(csr_wr_data)),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .mdio_in   (mdio_in),
        .active    (active),
        .mdio_out  (mdio_out),
        .mdio_oe   (mdio_oe),
        .done      (done),
        .rd_val    (rd_val)
    );

    assign csr_rd_data = cmd;

endmodule

// File: rtl/mdio_mgmt_master_chk.sv
module mdio_mgmt_master_chk (
    input logic        clk,
    input logic        rst,
    input logic        csr_wr_en,
    input logic [31:0] csr_wr_data,
    input logic [31:0] csr_rd_data,
    input logic        mdc,
    input logic        mdio_out,
    input logic        mdio_oe
);
    AST_GO_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
        (csr_wr_en && !csr_rd_data[31] && csr_wr_data[31]) |=> csr_rd_data[31]); // R1

    AST_BUSY_FIELDS_HELD: assert property (@(posedge clk) disable iff (rst)
        ($past(csr_rd_data[31]) && csr_rd_data[31])
            |-> (csr_rd_data[30:16] == $past(csr_rd_data[30:16]))); // R7

    AST_MDIO_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        (!$stable(mdio_out) && $past(csr_rd_data[31])) |-> $fell(mdc)); // R8

    AST_IDLE_MDC_LOW: assert property (@(posedge clk) disable iff (rst)
        !csr_rd_data[31] |-> !mdc); // R10

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
        !csr_rd_data[31] |-> !mdio_oe); // R10
endmodule

bind mdio_mgmt_master mdio_mgmt_master_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .csr_wr_en   (csr_wr_en),
    .csr_wr_data (csr_wr_data),
    .csr_rd_data (csr_rd_data),
    .mdc         (mdc),
    .mdio_out    (mdio_out),
    .mdio_oe     (mdio_oe)
);

// File: tb/mdio_mgmt_master_tb_top.sv
module mdio_mgmt_master_tb_top;
    localparam int HALF = 2;
    localparam int CLK_NS = 4;

    typedef struct {
        logic        is_rd;
        logic [4:0]  phy;
        logic [4:0]  rg;
        logic [15:0] data;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        csr_wr_en = 1'b0;
    logic [31:0] csr_wr_data = '0;
    logic [31:0] csr_rd_data;
    logic        mdc;
    logic        mdio_out;
    logic        mdio_oe;
    logic        mdio_in = 1'b1;

    int checks = 0;
    int errors = 0;
    int frames_seen = 0;
    int mdc_rises = 0;
    exp_t exp_q[$];

    always #(CLK_NS/2) clk = ~clk;

    mdio_mgmt_master #(.MDC_HALF_DIV(HALF)) dut_i (
        .clk (clk), .rst (rst),
        .csr_wr_en (csr_wr_en), .csr_wr_data (csr_wr_data),
        .csr_rd_data (csr_rd_data),
        .mdc (mdc), .mdio_out (mdio_out), .mdio_oe (mdio_oe),
        .mdio_in (mdio_in)
    );

    function automatic logic [15:0] phy_resp(logic [4:0] p, logic [4:0] r);
        return {p, r, ~p[2:0], r[2:0]} ^ 16'h5A3C;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h", tag, act, exp);
        end
    endtask

    // ---------------- PHY model / monitor ----------------
    logic [63:0] fv;
    logic [63:0] fo;
    int          bitcnt = 0;
    time         last_rise = 0;

    always @(posedge mdc) begin
        mdc_rises++;
        fv[63-bitcnt] = mdio_out;
        fo[63-bitcnt] = mdio_oe;
        if (bitcnt == 2) check("R8 mdc period", 32'($time - last_rise), 32'(2*HALF*CLK_NS));
        last_rise = $time;
        bitcnt++;
        if (bitcnt == 64) begin
            exp_t e;
            bitcnt = 0;
            frames_seen++;
            if (exp_q.size() == 0) begin
                check("R7 unexpected frame", 32'd1, 32'd0);
            end else begin
                e = exp_q.pop_front();
                check("R6 preamble", fv[63:32], 32'hFFFF_FFFF);
                check("R6 start", {30'd0, fv[31:30]}, 32'd1);
                check("R2 opcode", {30'd0, fv[29:28]}, e.is_rd ? 32'd2 : 32'd1);
                check("R3 phy addr", {27'd0, fv[27:23]}, {27'd0, e.phy});
                check("R3 reg addr", {27'd0, fv[22:18]}, {27'd0, e.rg});
                check("R6 driven head", {fo[63:18]} == {46{1'b1}} ? 32'd1 : 32'd0, 32'd1);
                if (e.is_rd) begin
                    check("R5 released tail", {14'd0, fo[17:0]}, 32'd0);
                end else begin
                    check("R4 turnaround", {30'd0, fv[17:16]}, 32'd2);
                    check("R4 write data", {16'd0, fv[15:0]}, {16'd0, e.data});
                    check("R4 driven tail", {14'd0, fo[17:0]}, 32'h3FFFF);
                end
            end
        end
    end

    always @(negedge mdc) begin
        if (bitcnt >= 48 && bitcnt <= 63 && fv[29] && !fv[28])
            mdio_in = phy_resp(fv[27:23], fv[22:18])[63-bitcnt];
        else
            mdio_in = 1'b1;
    end

    // ---------------- driver ----------------
    task automatic write_word(logic [31:0] w);
        @(negedge clk);
        csr_wr_en   = 1'b1;
        csr_wr_data = w;
        @(negedge clk);
        csr_wr_en   = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (csr_rd_data[31] === 1'b1 && n < 5000) begin
            @(negedge clk);
            n++;
        end
        check("R1 busy clears", {31'd0, csr_rd_data[31]}, 32'd0);
        check("R10 mdc low after", {31'd0, mdc}, 32'd0);
        check("R10 released after", {31'd0, mdio_oe}, 32'd0);
    endtask

    task automatic issue(logic is_rd, logic [4:0] p, logic [4:0] r, logic [15:0] d);
        logic [31:0] w;
        exp_t e;
        w = {1'b1, is_rd, 4'b0, p, r, d};
        e.is_rd = is_rd; e.phy = p; e.rg = r; e.data = d;
        exp_q.push_back(e);
        write_word(w);
        check("R1 busy set", {31'd0, csr_rd_data[31]}, 32'd1);
        wait_idle();
        check(is_rd ? "R5 read result" : "R4 write word kept", csr_rd_data,
              {1'b0, is_rd, 4'b0, p, r, is_rd ? phy_resp(p, r) : d});
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_NS * 150000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R9 reset word", csr_rd_data, 32'd0);
        check("R9 reset mdc", {31'd0, mdc}, 32'd0);
        check("R9 reset oe", {31'd0, mdio_oe}, 32'd0);

        // stored word without request flag
        write_word(32'h4123_4567);
        repeat (40) @(negedge clk);
        check("R1 no-go stored", csr_rd_data, 32'h4123_4567);
        check("R1 no-go no mdc", 32'(mdc_rises), 32'd0);

        issue(1'b0, 5'h01, 5'h00, 16'hBEEF);
        issue(1'b1, 5'h1F, 5'h1F, 16'h0000);
        issue(1'b1, 5'h00, 5'h00, 16'h1234);
        issue(1'b0, 5'h15, 5'h0A, 16'h0000);
        issue(1'b0, 5'h0A, 5'h15, 16'hFFFF);
        issue(1'b1, 5'h12, 5'h07, 16'hFFFF);

        // write while busy is ignored
        begin
            exp_t e;
            int fr0;
            e.is_rd = 1'b1; e.phy = 5'h09; e.rg = 5'h11; e.data = 16'h0;
            exp_q.push_back(e);
            write_word({1'b1, 1'b1, 4'b0, 5'h09, 5'h11, 16'h0});
            repeat (20) @(negedge clk);
            write_word(32'h8000_0000 | {1'b0, 1'b0, 4'hF, 5'h03, 5'h04, 16'hCAFE});
            check("R7 fields held mid-frame", {16'd0, csr_rd_data[31:16]},
                  {16'd0, 1'b1, 1'b1, 4'b0, 5'h09, 5'h11});
            wait_idle();
            check("R7 first command result", csr_rd_data,
                  {1'b0, 1'b1, 4'b0, 5'h09, 5'h11, phy_resp(5'h09, 5'h11)});
            fr0 = frames_seen;
            repeat (400) @(negedge clk);
            check("R7 no extra frame", 32'(frames_seen), 32'(fr0));
            check("R7 queue drained", 32'(exp_q.size()), 32'd0);
        end

        check("R6 frame count", 32'(frames_seen), 32'd7);
        finish_run();
    end

endmodule